// File: doc/BRIEF.md
# ROM Shadow and SMRAM Address Router

This block steers each memory request in the upper part of a 1 MB address space to either on-board DRAM or the external bus. It covers the ROM-shadow segments at C0000h through FFFFFh and a system-management RAM window that can sit in one of three places. One of these placements moves its window to a lower DRAM base. Requests come in over a valid/ready channel. Each one carries a 20-bit address, an access kind and a flag that says whether the processor is in system-management mode. The routing decision leaves on a second valid/ready channel one cycle after the request is accepted.

The configuration pins are plain levels that a register file outside this block holds steady. They are sampled in the cycle a request is accepted. The output channel has a single register stage. A request is accepted whenever that stage is empty or is being drained in the same cycle. While a result waits with `rsp_ready` low, `req_ready` stays low and the result does not change.

Top module: `shadow_smram_router`

## Requirements
- R1: Bit i of `cfg_lo_en` (i = 0..7) enables the 16 KB segment that starts at C0000h + i*4000h.
- R2: Bit i of `cfg_hi_en` (i = 0..3) enables the 32 KB segment that starts at E0000h + i*8000h.
- R3: In an enabled segment, a read (`req_kind` 00, or the unused code 11) or a code fetch (10) goes to DRAM when `cfg_rd_dram` is 1. A write (01) goes to DRAM when `cfg_wr_dram` is 1. In every other case the access goes to the external bus.
- R4: When `cfg_smram_mode` is 01, addresses A0000h–BFFFFh are an SMRAM hit. A hit goes to DRAM with the address unchanged.
- R5: When `cfg_smram_mode` is 10, addresses E0000h–EFFFFh are an SMRAM hit with the address unchanged, but only while `cfg_hi_en[1:0]` is 00. Otherwise these addresses follow the shadow rules.
- R6: When `cfg_smram_mode` is 11, addresses A8000h–AFFFFh are an SMRAM hit. The DRAM address is the offset inside the window added to 68000h when `cfg_reloc_sel` is 10, and to 38000h for any other value.
- R7: When `cfg_smram_mode` is 00, no address is an SMRAM hit and no code-fetch redirect applies.
- R8: A window address counts as a hit only when `req_smm` or `cfg_smram_open` is 1. Otherwise it is decoded as if the window did not exist, except as stated in R9.
- R9: When the mode is 01 and `cfg_fetch_dram` is 1, a code fetch in A0000h–BFFFFh that is not a hit goes to DRAM with the address unchanged and `rsp_smram_hit` at 0.
- R10: An address that no enabled segment or active window covers goes to the external bus (`rsp_dram` 0) with the address unchanged and `rsp_smram_hit` at 0.
- R11: `req_ready` equals (not `rsp_valid`) or `rsp_ready`. The result of a request accepted at a clock edge is on the outputs right after that edge. It stays there unchanged while `rsp_valid` is 1 and `rsp_ready` is 0.
- R12: During and right after reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when also valid |
| req_addr | input | 20 | Memory address |
| req_kind | input | 2 | 00 read, 01 write, 10 code fetch, 11 treated as read |
| req_smm | input | 1 | Requester is in system-management mode |
| cfg_lo_en | input | 8 | 16 KB segment enables, C0000h–DFFFFh |
| cfg_hi_en | input | 4 | 32 KB segment enables, E0000h–FFFFFh |
| cfg_rd_dram | input | 1 | Reads and fetches of enabled segments go to DRAM |
| cfg_wr_dram | input | 1 | Writes of enabled segments go to DRAM |
| cfg_smram_mode | input | 2 | SMRAM window placement: 00 off, 01 A0000h, 10 E0000h, 11 A8000h relocated |
| cfg_smram_open | input | 1 | Window visible outside system-management mode |
| cfg_fetch_dram | input | 1 | Code fetches in A0000h–BFFFFh go to DRAM in mode 01 |
| cfg_reloc_sel | input | 2 | Value 10 picks the 68000h base for mode 11, others pick 38000h |
| rsp_valid | output | 1 | Routing result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_dram | output | 1 | 1: internal DRAM, 0: external bus |
| rsp_smram_hit | output | 1 | Access falls in an active SMRAM window |
| rsp_addr | output | 20 | Address to present to the selected target |

## Verification
Two cases can meet in a single request. The first is the E0000h window meeting the high shadow segments: with mode 10, the same address is driven once with `cfg_hi_en[1:0]` at zero and again with one of those bits set, and the outcome must flip from a window hit to a shadow or external decision. The second is the A0000h window meeting the code-fetch redirect: a fetch in that range with `cfg_fetch_dram` set is sent both inside and outside system-management mode, and the hit flag must appear only in the first case while DRAM is chosen in both. Randomized configurations and addresses weighted toward A0000h–FFFFFh create many more such overlaps, and every result is compared against a bench model of the requirements. A stall sequence holds `rsp_ready` low while a second request waits, to show the held result stays the same and the waiting request is taken only on release.

// File: rtl/shadow_smram_pkg.sv
package shadow_smram_pkg;
  parameter int ADDR_W = 20;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    WIN_OFF   = 2'b00,
    WIN_A_ALL = 2'b01,
    WIN_E_LOW = 2'b10,
    WIN_A_REL = 2'b11
  } win_mode_e;

  typedef struct packed {
    logic              dram;
    logic              smram_hit;
    logic [ADDR_W-1:0] addr;
  } route_t;

  localparam int ROUTE_W = $bits(route_t);
endpackage

// File: rtl/shadow_seg_map.sv
module shadow_seg_map
  import shadow_smram_pkg::*;
#(
  parameter int                N_SEG    = 8,
  parameter int                SEG_LOG2 = 14,
  parameter logic [ADDR_W-1:0] BASE     = 20'hC0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SEG-1:0]  seg_en,
  output logic              en_hit
);
  localparam int TAG_W = ADDR_W - SEG_LOG2;
  localparam longint unsigned SPAN_LO = longint'(BASE);
  localparam longint unsigned SPAN_HI = SPAN_LO + (longint'(N_SEG) << SEG_LOG2);

  logic [N_SEG-1:0] seg_match;

  for (genvar i = 0; i < N_SEG; i++) begin : g_seg
    localparam logic [ADDR_W-1:0] SEG_START =
      ADDR_W'(longint'(BASE) + (longint'(i) << SEG_LOG2));
    assign seg_match[i] = (addr[ADDR_W-1:SEG_LOG2] == SEG_START[ADDR_W-1:SEG_LOG2]);
  end

  assign en_hit = |(seg_match & seg_en);

  AST_SEG_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    en_hit |-> ((longint'(addr) >= SPAN_LO) && (longint'(addr) < SPAN_HI)));  // R1

  AST_SEG_NONE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_en == '0) |-> !en_hit);  // R2

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = '0;
endmodule

// File: rtl/smram_window.sv
module smram_window
  import shadow_smram_pkg::*;
#(
  parameter int                A_LOG2    = 17,
  parameter logic [ADDR_W-1:0] A_BASE    = 20'hA0000,
  parameter int                E_LOG2    = 16,
  parameter logic [ADDR_W-1:0] E_BASE    = 20'hE0000,
  parameter int                R_LOG2    = 15,
  parameter logic [ADDR_W-1:0] R_BASE    = 20'hA8000,
  parameter logic [ADDR_W-1:0] RELOC_ALT = 20'h68000,
  parameter logic [ADDR_W-1:0] RELOC_DEF = 20'h38000,
  parameter logic [1:0]        ALT_CODE  = 2'b10,
  parameter int                E_SEGS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_fetch,
  input  logic              smm,
  input  logic [1:0]        mode,
  input  logic              open,
  input  logic              fetch_dram,
  input  logic [1:0]        reloc_sel,
  input  logic [E_SEGS-1:0] e_seg_en,
  output logic              hit,
  output logic              fetch_bypass,
  output logic [ADDR_W-1:0] win_addr
);
  logic in_a, in_e, in_r, visible, in_win;
  logic [ADDR_W-1:0] reloc_base;

  assign in_a    = (addr[ADDR_W-1:A_LOG2] == A_BASE[ADDR_W-1:A_LOG2]);
  assign in_e    = (addr[ADDR_W-1:E_LOG2] == E_BASE[ADDR_W-1:E_LOG2]);
  assign in_r    = (addr[ADDR_W-1:R_LOG2] == R_BASE[ADDR_W-1:R_LOG2]);
  assign visible = smm | open;

  always_comb begin
    unique case (win_mode_e'(mode))
      WIN_A_ALL: in_win = in_a;
      WIN_E_LOW: in_win = in_e && (e_seg_en == '0);
      WIN_A_REL: in_win = in_r;
      default:   in_win = 1'b0;
    endcase
  end

  assign hit          = in_win && visible;
  assign fetch_bypass = (win_mode_e'(mode) == WIN_A_ALL) && fetch_dram && is_fetch && in_a;
  assign reloc_base   = (reloc_sel == ALT_CODE) ? RELOC_ALT : RELOC_DEF;

  always_comb begin
    if (win_mode_e'(mode) == WIN_A_REL)
      win_addr = {reloc_base[ADDR_W-1:R_LOG2], addr[R_LOG2-1:0]};
    else
      win_addr = addr;
  end

  AST_HIT_NEEDS_SMM: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (smm || open));  // R8

  AST_E_WIN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b10) && (e_seg_en != '0)) |-> !hit);  // R5

  AST_RELOC_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (mode == 2'b11)) |->
      ((win_addr[ADDR_W-1:R_LOG2] == RELOC_ALT[ADDR_W-1:R_LOG2]) ||
       (win_addr[ADDR_W-1:R_LOG2] == RELOC_DEF[ADDR_W-1:R_LOG2])));  // R6

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (!hit && !fetch_bypass));  // R7
endmodule

// File: rtl/route_stage.sv
module route_stage #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R11

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);  // R11
endmodule

// File: rtl/shadow_smram_router.sv
module shadow_smram_router
  import shadow_smram_pkg::*;
#(
  parameter int N_LO    = 8,
  parameter int LO_LOG2 = 14,
  parameter int N_HI    = 4,
  parameter int HI_LOG2 = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_smm,
  input  logic [N_LO-1:0]   cfg_lo_en,
  input  logic [N_HI-1:0]   cfg_hi_en,
  input  logic              cfg_rd_dram,
  input  logic              cfg_wr_dram,
  input  logic [1:0]        cfg_smram_mode,
  input  logic              cfg_smram_open,
  input  logic              cfg_fetch_dram,
  input  logic [1:0]        cfg_reloc_sel,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_dram,
  output logic              rsp_smram_hit,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int E_LOG2 = 16;
  localparam int E_SEGS = 1 << (E_LOG2 - HI_LOG2);
  localparam logic [ADDR_W-1:0] LO_BASE = 20'hC0000;
  localparam logic [ADDR_W-1:0] HI_BASE = 20'hE0000;

  logic lo_hit, hi_hit, seg_hit, is_write, is_fetch, seg_to_dram;
  logic win_hit, fetch_bypass;
  logic [ADDR_W-1:0] win_addr;
  route_t route_d, route_q;

  assign is_write = (acc_kind_e'(req_kind) == KIND_WRITE);
  assign is_fetch = (acc_kind_e'(req_kind) == KIND_FETCH);

  shadow_seg_map #(.N_SEG(N_LO), .SEG_LOG2(LO_LOG2), .BASE(LO_BASE)) u_lo_map (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .seg_en(cfg_lo_en), .en_hit(lo_hit)
  );

  shadow_seg_map #(.N_SEG(N_HI), .SEG_LOG2(HI_LOG2), .BASE(HI_BASE)) u_hi_map (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .seg_en(cfg_hi_en), .en_hit(hi_hit)
  );

  smram_window #(.E_LOG2(E_LOG2), .E_BASE(HI_BASE), .E_SEGS(E_SEGS)) u_window (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .is_fetch(is_fetch), .smm(req_smm),
    .mode(cfg_smram_mode), .open(cfg_smram_open), .fetch_dram(cfg_fetch_dram),
    .reloc_sel(cfg_reloc_sel), .e_seg_en(cfg_hi_en[E_SEGS-1:0]),
    .hit(win_hit), .fetch_bypass(fetch_bypass), .win_addr(win_addr)
  );

  assign seg_hit     = lo_hit || hi_hit;
  assign seg_to_dram = seg_hit && (is_write ? cfg_wr_dram : cfg_rd_dram);

  always_comb begin
    route_d = '{dram: 1'b0, smram_hit: 1'b0, addr: req_addr};
    if (win_hit)
      route_d = '{dram: 1'b1, smram_hit: 1'b1, addr: win_addr};
    else if (fetch_bypass || seg_to_dram)
      route_d.dram = 1'b1;
  end

  route_stage #(.W(ROUTE_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(route_d),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(route_q)
  );

  assign rsp_dram      = route_q.dram;
  assign rsp_smram_hit = route_q.smram_hit;
  assign rsp_addr      = route_q.addr;

  AST_HIT_IS_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_smram_hit) |-> rsp_dram);  // R4

  AST_EXT_NO_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !win_hit) |=> (rsp_addr == $past(req_addr)));  // R10
endmodule

// File: tb/shadow_smram_router_bench.sv
module shadow_smram_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_smm = 1'b0;
  logic [7:0]  cfg_lo_en = '0;
  logic [3:0]  cfg_hi_en = '0;
  logic        cfg_rd_dram = 1'b0, cfg_wr_dram = 1'b0;
  logic [1:0]  cfg_smram_mode = '0;
  logic        cfg_smram_open = 1'b0, cfg_fetch_dram = 1'b0;
  logic [1:0]  cfg_reloc_sel = '0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_dram, rsp_smram_hit;
  logic [19:0] rsp_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  shadow_smram_router u_shadow_smram_router (.*);

  function automatic logic [21:0] model(input logic [19:0] a, input logic [1:0] k,
                                        input logic s, output string tag);
    logic vis, en;
    int idx;
    vis = s | cfg_smram_open;
    if (cfg_smram_mode == 2'b01 && a >= 20'hA0000 && a <= 20'hBFFFF) begin
      if (vis) begin tag = "R4"; return {2'b11, a}; end
      if (cfg_fetch_dram && k == 2'b10) begin tag = "R9"; return {2'b10, a}; end
    end
    if (cfg_smram_mode == 2'b10 && cfg_hi_en[1:0] == 2'b00 && vis &&
        a >= 20'hE0000 && a <= 20'hEFFFF) begin
      tag = "R5"; return {2'b11, a};
    end
    if (cfg_smram_mode == 2'b11 && vis && a >= 20'hA8000 && a <= 20'hAFFFF) begin
      tag = "R6";
      return {2'b11, (cfg_reloc_sel == 2'b10 ? 20'h68000 : 20'h38000) + (a - 20'hA8000)};
    end
    en = 1'b0;
    if (a >= 20'hC0000 && a <= 20'hDFFFF) begin
      idx = int'((a - 20'hC0000) >> 14); en = cfg_lo_en[idx]; tag = "R1";
    end else if (a >= 20'hE0000) begin
      idx = int'((a - 20'hE0000) >> 15); en = cfg_hi_en[idx]; tag = "R2";
    end else tag = "R10";
    if (en) begin
      if (k == 2'b01 ? cfg_wr_dram : cfg_rd_dram) return {2'b10, a};
      tag = "R3";
    end
    return {2'b00, a};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] lo, input logic [3:0] hi, input logic rd, input logic wr,
                     input logic [1:0] md, input logic op, input logic fd, input logic [1:0] rs);
    @(negedge clk);
    cfg_lo_en = lo; cfg_hi_en = hi; cfg_rd_dram = rd; cfg_wr_dram = wr;
    cfg_smram_mode = md; cfg_smram_open = op; cfg_fetch_dram = fd; cfg_reloc_sel = rs;
  endtask

  task automatic xact(input logic [19:0] a, input logic [1:0] k, input logic s, input string note);
    logic [21:0] e;
    string tag;
    @(negedge clk);
    req_addr = a; req_kind = k; req_smm = s; req_valid = 1'b1; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    e = model(a, k, s, tag);
    if (note != "") tag = note;
    check(tag, {9'd0, rsp_valid, rsp_dram, rsp_smram_hit, rsp_addr}, {9'd0, 1'b1, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] a;
    void'($urandom(32'h1DEC0DE));
    repeat (3) @(posedge clk);
    #1;
    check("R12 valid in reset", {31'd0, rsp_valid}, 32'd0);
    check("R12 ready in reset", {31'd0, req_ready}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R12 valid after reset", {31'd0, rsp_valid}, 32'd0);

    // R1 low segment boundaries
    cfg(8'b0000_0100, 4'h0, 1, 1, 2'b00, 0, 0, 2'b00);
    xact(20'hC8000, 2'b00, 0, "R1 seg2 start");
    xact(20'hC7FFF, 2'b00, 0, "R1 seg1 off");
    xact(20'hCBFFF, 2'b00, 0, "R1 seg2 end");
    xact(20'hCC000, 2'b00, 0, "R1 seg3 off");
    // R2 high segment boundaries
    cfg(8'h00, 4'b1000, 1, 1, 2'b00, 0, 0, 2'b00);
    xact(20'hF8000, 2'b00, 0, "R2 seg3 start");
    xact(20'hF7FFF, 2'b00, 0, "R2 seg2 off");
    xact(20'hFFFFF, 2'b11, 0, "R2 top as read");
    // R3 read/write control split
    cfg(8'hFF, 4'hF, 1, 0, 2'b00, 0, 0, 2'b00);
    xact(20'hD0000, 2'b01, 0, "R3 write external");
    xact(20'hD0000, 2'b10, 0, "R3 fetch dram");
    cfg(8'hFF, 4'hF, 0, 1, 2'b00, 0, 0, 2'b00);
    xact(20'hD0000, 2'b01, 0, "R3 write dram");
    xact(20'hD0000, 2'b10, 0, "R3 fetch external");
    // R4 and R8 A window
    cfg(8'hFF, 4'h0, 1, 1, 2'b01, 0, 0, 2'b00);
    xact(20'hA0000, 2'b00, 1, "R4 low edge");
    xact(20'hBFFFF, 2'b01, 1, "R4 high edge");
    xact(20'hC0000, 2'b00, 1, "R4 past window");
    xact(20'hA5000, 2'b00, 0, "R8 outside smm");
    cfg(8'hFF, 4'h0, 1, 1, 2'b01, 1, 0, 2'b00);
    xact(20'hA5000, 2'b00, 0, "R8 open visible");
    // R5 E window blocking
    cfg(8'h00, 4'b0000, 1, 1, 2'b10, 0, 0, 2'b00);
    xact(20'hE1234, 2'b00, 1, "R5 window");
    cfg(8'h00, 4'b0001, 1, 1, 2'b10, 0, 0, 2'b00);
    xact(20'hE1234, 2'b00, 1, "R5 blocked shadow");
    cfg(8'h00, 4'b0010, 1, 1, 2'b10, 0, 0, 2'b00);
    xact(20'hE1234, 2'b00, 1, "R5 blocked external");
    cfg(8'h00, 4'b0100, 1, 1, 2'b10, 0, 0, 2'b00);
    xact(20'hE1234, 2'b00, 1, "R5 upper seg no block");
    xact(20'hF0000, 2'b00, 1, "R5 upper seg shadow");
    // R6 relocation
    cfg(8'h00, 4'h0, 0, 0, 2'b11, 0, 0, 2'b10);
    xact(20'hA8010, 2'b00, 1, "R6 alt base");
    cfg(8'h00, 4'h0, 0, 0, 2'b11, 0, 0, 2'b01);
    xact(20'hA8010, 2'b00, 1, "R6 default base");
    cfg(8'h00, 4'h0, 0, 0, 2'b11, 0, 0, 2'b00);
    xact(20'hAFFFF, 2'b01, 1, "R6 window end");
    xact(20'hA7FFF, 2'b00, 1, "R6 below window");
    xact(20'hB0000, 2'b00, 1, "R6 above window");
    // R7 off
    cfg(8'h00, 4'h0, 1, 1, 2'b00, 1, 1, 2'b10);
    xact(20'hA8000, 2'b00, 1, "R7 no window");
    xact(20'hA0000, 2'b10, 0, "R7 no fetch redirect");
    // R9 fetch redirect
    cfg(8'h00, 4'h0, 0, 0, 2'b01, 0, 1, 2'b00);
    xact(20'hA1000, 2'b10, 0, "R9 fetch dram");
    xact(20'hA1000, 2'b00, 0, "R9 read external");
    xact(20'hA1000, 2'b10, 1, "R9 fetch in smm hit");
    cfg(8'h00, 4'h0, 0, 0, 2'b01, 0, 0, 2'b00);
    xact(20'hA1000, 2'b10, 0, "R9 redirect off");
    // R10 default
    cfg(8'hFF, 4'hF, 1, 1, 2'b01, 1, 1, 2'b10);
    xact(20'h12345, 2'b10, 1, "R10 low memory");

    // R11 back-pressure
    cfg(8'h01, 4'h0, 1, 1, 2'b00, 0, 0, 2'b00);
    @(negedge clk);
    rsp_ready = 1'b0; req_addr = 20'hC0010; req_kind = 2'b00; req_smm = 0; req_valid = 1'b1;
    @(negedge clk);
    check("R11 first result", {11'd0, rsp_valid, rsp_dram, rsp_addr}, {11'd0, 2'b11, 20'hC0010});
    check("R11 ready low on stall", {31'd0, req_ready}, 32'd0);
    req_addr = 20'h54321;
    repeat (3) @(negedge clk);
    check("R11 held result", {11'd0, rsp_valid, rsp_dram, rsp_addr}, {11'd0, 2'b11, 20'hC0010});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 second after release", {11'd0, rsp_valid, rsp_dram, rsp_addr}, {11'd0, 2'b10, 20'h54321});
    @(negedge clk);
    check("R11 drained", {31'd0, rsp_valid}, 32'd0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      cfg(8'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
          ($urandom % 4) == 0, 1'($urandom), 2'($urandom));
      case ($urandom % 4)
        0: a = 20'hA0000 + 20'($urandom % 20'h20000);
        1: a = 20'hC0000 + 20'($urandom % 20'h20000);
        2: a = 20'hE0000 + 20'($urandom % 20'h20000);
        default: a = 20'($urandom);
      endcase
      xact(a, 2'($urandom), 1'($urandom), "");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule